// File: doc/BRIEF.md
# Deterministic Ring-Register Test Pattern Generator

This block is an on-chip source of deterministic test vectors for built-in self-test. It steps through a fixed, ordered list of distinct W-bit vectors, one per enabled clock cycle, without storing seeds in a ROM. The storage is a ring of W flip-flop stages. Each stage is set at elaboration to one of four cell styles: plain D, D with an inverted input, T, or T with an inverted input. An inverted T cell is built with an XNOR in place of the toggle XOR. A purely combinational correction decoder looks at the present ring contents and drives one correction bit into each stage, so the next ring state is always the next vector required.

The vector list, the order in which it is played, and a common permutation of bit positions are all elaboration parameters. The order and the permutation change only the correction decoder and the output wiring. The ring stage that holds a given pattern bit is chosen by the permutation, and the output always presents bits in their original positions.

A small sequencer tracks where the generator is in the list. Its state ST_FIRST means the first vector is on the output. ST_MIDDLE covers any vector between the first and the last. ST_FINAL means the last vector is on the output. The enabled transitions are these. FIRST goes to MIDDLE, or straight to FINAL when the list has two entries. MIDDLE goes to FINAL once the second-to-last vector has been shown. FINAL goes back to FIRST, which is the wrap. With enable low, every state holds.

Top module: `ring_tpg`

## Requirements
- R1: While rst_n is low, pattern_o equals the first vector of the play order and done_o is 0.
- R2: On each rising clock edge with en high, pattern_o advances to the next vector of the play order, with no other vector in between.
- R3: On a rising clock edge with en low, pattern_o and done_o keep their values.
- R4: done_o is 1 exactly when the last vector of the play order is on pattern_o.
- R5: An enabled edge while the last vector is shown returns pattern_o to the first vector, and done_o falls.
- R6: The sequence on pattern_o is the same for every setting of the per-stage type mask (bit j = 1 makes stage j a T cell) and the inversion mask (bit j = 1 inverts the input of stage j).
- R7: Any bit permutation (entry p, PW bits wide at [p*PW +: PW], names the pattern bit held in ring stage p) leaves the sequence on pattern_o unchanged.
- R8: The play order parameter (entry k, IW bits wide at [k*IW +: IW], indexes the vector list, whose entry n sits at [n*W +: W]) sets the sequence on pattern_o.
- R9: Pulling rst_n low between clock edges sets pattern_o to the first vector at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance to the next vector on this edge |
| pattern_o | output | W | Current test vector, bits in their original positions |
| done_o | output | 1 | High while the last vector of the play order is shown |

## Verification
The assertions assume that the listed vectors are pairwise distinct and that the list holds at least two entries. Without that, a present state cannot pick a unique successor, and "the vector changes on every enabled edge" would not hold. They also assume that the permutation parameter is a true bijection. Every bench configuration plays the same six distinct 3-bit vectors under a full permutation and a full order, so it stays within these assumptions. Enable is toggled in an irregular pattern, and reset is released only at a falling clock edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_MIDDLE = 2'd1,
        ST_FINAL  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tpg_stage.sv
module tpg_stage #(
    parameter bit IS_T    = 1'b0,
    parameter bit HAS_INV = 1'b0,
    parameter bit RST_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic shift_in,
    input  logic corr,
    output logic q
);

    logic d_next;
    logic drive;

    assign drive = shift_in ^ corr;

    generate
        if (IS_T && HAS_INV) begin : g_t_inv
            assign d_next = ~(q ^ drive);
        end else if (IS_T) begin : g_t
            assign d_next = q ^ drive;
        end else if (HAS_INV) begin : g_d_inv
            assign d_next = ~drive;
        end else begin : g_d
            assign d_next = drive;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_BIT;
        end else if (en) begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/tpg_decoder.sv
module tpg_decoder #(
    parameter int           W      = 3,
    parameter int           N      = 6,
    parameter logic [W-1:0] T_MASK = '0,
    parameter logic [W-1:0] I_MASK = '0
) (
    input  logic [W-1:0] q,
    input  logic [W-1:0] req_tab [N],
    output logic [W-1:0] corr
);

    logic [W-1:0] shift_vec;

    assign shift_vec = {q[W-2:0], q[W-1]};

    always_comb begin
        corr = '0;
        for (int k = 0; k < N; k++) begin
            if (q == req_tab[k]) begin
                corr = shift_vec ^ (T_MASK & q) ^ I_MASK ^ req_tab[(k + 1) % N];
            end
        end
    end

endmodule

// File: rtl/tpg_seq_fsm.sv
module tpg_seq_fsm
    import tpg_pkg::*;
#(
    parameter int N  = 6,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);

    seq_state_e state;
    seq_state_e state_nx;
    logic [IW-1:0] idx;
    logic [IW-1:0] idx_nx;

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        if (en) begin
            unique case (state)
                ST_FIRST: begin
                    idx_nx   = IW'(1);
                    state_nx = (N == 2) ? ST_FINAL : ST_MIDDLE;
                end
                ST_MIDDLE: begin
                    idx_nx   = idx + IW'(1);
                    state_nx = (idx == IW'(N - 2)) ? ST_FINAL : ST_MIDDLE;
                end
                ST_FINAL: begin
                    idx_nx   = '0;
                    state_nx = ST_FIRST;
                end
                default: begin
                    idx_nx   = '0;
                    state_nx = ST_FIRST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FIRST;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        done = (state == ST_FINAL);
    end

endmodule

// File: rtl/ring_tpg.sv
module ring_tpg #(
    parameter int                W      = 3,
    parameter int                N      = 6,
    parameter int                IW     = (N > 1) ? $clog2(N) : 1,
    parameter int                PW     = (W > 1) ? $clog2(W) : 1,
    parameter logic [N*W-1:0]    VECS   = {3'd2, 3'd7, 3'd4, 3'd3, 3'd6, 3'd1},
    parameter logic [N*IW-1:0]   ORDER  = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    parameter logic [W*PW-1:0]   PERM   = {2'd2, 2'd1, 2'd0},
    parameter logic [W-1:0]      T_MASK = 3'b010,
    parameter logic [W-1:0]      I_MASK = 3'b010
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] pattern_o,
    output logic         done_o
);

    // Vector k of the play order, laid out in ring-stage positions.
    function automatic logic [W-1:0] ring_word(input int k);
        logic [W-1:0] w;
        int           src;
        w   = '0;
        src = int'(ORDER[k*IW +: IW]);
        for (int p = 0; p < W; p++) begin
            w[p] = VECS[src*W + int'(PERM[p*PW +: PW])];
        end
        return w;
    endfunction

    localparam logic [W-1:0] FIRST_WORD = ring_word(0);

    logic [W-1:0] q;
    logic [W-1:0] corr;
    logic [W-1:0] req_tab [N];

    generate
        for (genvar k = 0; k < N; k++) begin : g_tab
            assign req_tab[k] = ring_word(k);
        end

        for (genvar j = 0; j < W; j++) begin : g_stage
            tpg_stage #(
                .IS_T    (T_MASK[j]),
                .HAS_INV (I_MASK[j]),
                .RST_BIT (FIRST_WORD[j])
            ) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en),
                .shift_in (q[(j + W - 1) % W]),
                .corr     (corr[j]),
                .q        (q[j])
            );
        end
    endgenerate

    tpg_decoder #(
        .W      (W),
        .N      (N),
        .T_MASK (T_MASK),
        .I_MASK (I_MASK)
    ) u_dec (
        .q       (q),
        .req_tab (req_tab),
        .corr    (corr)
    );

    tpg_seq_fsm #(
        .N  (N),
        .IW (IW)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .done  (done_o)
    );

    always_comb begin
        pattern_o = '0;
        for (int p = 0; p < W; p++) begin
            pattern_o[PERM[p*PW +: PW]] = q[p];
        end
    end

endmodule

// File: rtl/ring_tpg_chk.sv
module ring_tpg_chk #(
    parameter int              W     = 3,
    parameter int              N     = 6,
    parameter int              IW    = 3,
    parameter logic [N*W-1:0]  VECS  = '0,
    parameter logic [N*IW-1:0] ORDER = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [W-1:0] pattern_o,
    input logic         done_o
);

    localparam logic [W-1:0] HEAD = VECS[int'(ORDER[0 +: IW])*W +: W];
    localparam logic [W-1:0] TAIL = VECS[int'(ORDER[(N-1)*IW +: IW])*W +: W];

    AST_STEP_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> pattern_o != $past(pattern_o)); // R2

    AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pattern_o)); // R3

    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(done_o)); // R3

    AST_DONE_SHOWS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pattern_o == TAIL); // R4

    AST_TAIL_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_o == TAIL |-> done_o); // R4

    AST_WRAP_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && en |=> pattern_o == HEAD && !done_o); // R5

endmodule

bind ring_tpg ring_tpg_chk #(
    .W     (W),
    .N     (N),
    .IW    (IW),
    .VECS  (VECS),
    .ORDER (ORDER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pattern_o (pattern_o),
    .done_o    (done_o)
);

// File: tb/ring_tpg_tb.sv
module ring_tpg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NV = 6;

    localparam logic [17:0] VECS_P = {3'd2, 3'd7, 3'd4, 3'd3, 3'd6, 3'd1};

    int vec_tb [NV] = '{1, 6, 3, 4, 7, 2};
    int ord_tb [NC][NV] = '{'{0, 1, 2, 3, 4, 5},
                            '{5, 4, 3, 2, 1, 0},
                            '{0, 1, 2, 5, 4, 3},
                            '{3, 0, 5, 1, 4, 2}};
    string cfg_tag [NC] = '{"cfgA R8", "cfgB R6 R7 R8", "cfgC R6 R7 R8", "cfgD R6 R7 R8"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] pat [NC];
    logic       dn  [NC];
    int         idx [NC];
    int         n_tests = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_tpg #(.VECS(VECS_P), .ORDER({3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}),
               .PERM({2'd2, 2'd1, 2'd0}), .T_MASK(3'b000), .I_MASK(3'b000))
        u_dut (.clk(clk), .rst_n(rst_n), .en(en), .pattern_o(pat[0]), .done_o(dn[0]));

    ring_tpg #(.VECS(VECS_P), .ORDER({3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5}),
               .PERM({2'd0, 2'd1, 2'd2}), .T_MASK(3'b111), .I_MASK(3'b111))
        u_dut_b (.clk(clk), .rst_n(rst_n), .en(en), .pattern_o(pat[1]), .done_o(dn[1]));

    ring_tpg #(.VECS(VECS_P), .ORDER({3'd3, 3'd4, 3'd5, 3'd2, 3'd1, 3'd0}),
               .PERM({2'd1, 2'd2, 2'd0}), .T_MASK(3'b010), .I_MASK(3'b010))
        u_dut_c (.clk(clk), .rst_n(rst_n), .en(en), .pattern_o(pat[2]), .done_o(dn[2]));

    ring_tpg #(.VECS(VECS_P), .ORDER({3'd2, 3'd4, 3'd1, 3'd5, 3'd0, 3'd3}),
               .PERM({2'd0, 2'd2, 2'd1}), .T_MASK(3'b101), .I_MASK(3'b011))
        u_dut_d (.clk(clk), .rst_n(rst_n), .en(en), .pattern_o(pat[3]), .done_o(dn[3]));

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NC; c++) begin
            chk({tag, " ", cfg_tag[c], " pattern"}, int'(pat[c]), vec_tb[ord_tb[c][idx[c]]]);
            chk({tag, " R4 ", cfg_tag[c], " done"}, int'(dn[c]), (idx[c] == NV - 1) ? 1 : 0);
        end
    endtask

    task automatic step(input logic e);
        en = e;
        @(posedge clk);
        if (e) begin
            for (int c = 0; c < NC; c++) idx[c] = (idx[c] + 1) % NV;
        end
        @(negedge clk);
        if (e) check_all("R2 R5");
        else   check_all("R3");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) idx[c] = 0;
        repeat (2) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            step(!((cyc % 7 == 3) || (cyc % 11 == 5)));
        end
        // park on the final vector of cfgA and idle there
        while (idx[0] != NV - 1) step(1'b1);
        for (int h = 0; h < 3; h++) step(1'b0);
        step(1'b1);
        for (int s = 0; s < 3; s++) step(1'b1);
        // asynchronous reset between edges
        en = 1'b1;
        #2;
        rst_n = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) idx[c] = 0;
        check_all("R9");
        en = 1'b0;
        @(negedge clk);
        check_all("R1 R9");
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 30; cyc++) begin
            step(cyc % 4 != 2);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule